// File: doc/BRIEF.md
# Cache Error Log Registers

This block records error reports from a cache pipeline. Each report is a strobe with a vector of error-type flags and one physical address for each type. The block keeps the first report it sees. Software reads the result from three registers through a small read/write port.

The first event after a clear sets a capture-valid bit and the type bits of that event, and it stores the address of its most severe type. Any later event that arrives while capture-valid is still set only raises a multiple-error flag. Software clears status bits by writing ones to them. A level interrupt is raised while a capture is held and at least one captured type is enabled.

Register select (`reg_addr_i`):

| Value | Register |
|-------|----------|
| 0 | status |
| 1 | address (read only) |
| 2 | interrupt enable |
| 3 | reads as zero |

Error type index:

| Index | Error type |
|-------|------------|
| 0 | uncorrectable data |
| 1 | uncorrectable tag |
| 2 | correctable data (load) |
| 3 | correctable tag |

A lower index has higher priority.

Top module: `cache_err_log`

## Requirements
- R1: After reset, the status register, the address register and the enable register all read as zero, and `irq_o` is low.
- R2: An event (strobe high, type vector non-zero) that arrives while capture-valid (status bit 62) is clear is visible on the next cycle. It sets bit 62 and the type bits of the event, and it stores the address. Type index k is shown at status bit 61-k, so a correctable data error on a load sets bits 62 and 59.
- R3: An event that arrives while bit 62 is set, with no status write in the same cycle, sets the multiple-error bit (status bit 63). The type bits and the address register do not change.
- R4: A write to status clears each of bits 63, 62 and 61 down to 62-NUM_ERR where the written data holds a one. A zero in the written data leaves that bit unchanged.
- R5: Once software has cleared bit 62, the next event is captured as a new first event. It replaces the type field and loads the address, and bit 63 stays clear.
- R6: When one event carries several type flags, all of their status bits are set. The stored address is taken from the lowest set index, so an uncorrectable type wins over a correctable one.
- R7: The address register returns the captured address in bits [PA_W-1:3]. Bits [2:0] and all bits above PA_W-1 read as zero.
- R8: The enable register keeps bits [NUM_ERR-1:0] of the last value written to it. `irq_o` is high exactly when bit 62 is set and at least one captured type bit has its enable bit set.
- R9: When a status write and an event fall in the same cycle, the clear is applied first and the event second. The bits the event sets are therefore the ones that survive: a full clear together with an event gives a fresh capture, and a clear of bit 63 together with an event while bit 62 stays set leaves bit 63 set.
- R10: The following leave the registers unchanged: writes to the address register, strobes with an all-zero type vector, and type flags without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| err_valid_i | input | 1 | Error event strobe |
| err_type_i | input | NUM_ERR | Error type flags; index 0 has the highest priority |
| err_addr_i | input | NUM_ERR x PA_W | Physical address for each type |
| reg_en_i | input | 1 | Register access enable |
| reg_we_i | input | 1 | Register write (with reg_en_i) |
| reg_addr_i | input | 2 | Register select (0 status, 1 address, 2 enable) |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
Single-type events are applied in two states: idle and already capturing. The first shows the capture path and the second shows the multiple-error path, which must leave the type bits and the address untouched. An event with two types set shows that address priority is by index and that type bits merge. Status writes are tried with a zero mask, a partial mask and a full mask, and are also placed in the same cycle as an event. This tells apart a per-bit clear from a whole-register clear, and it shows that the event wins over the clear. Strobes without type flags, type flags without a strobe, and writes to the read-only address register are then checked to leave every register as it was.

// File: rtl/cel_pkg.sv
package cel_pkg;
    localparam int unsigned REG_W    = 64;
    localparam int unsigned MEC_BIT  = 63;
    localparam int unsigned VLD_BIT  = 62;
    localparam int unsigned TYPE_TOP = 61;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ADDR   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cel_prio_pick.sv
// Fixed-priority address pick: the lowest set request index wins.
module cel_prio_pick #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 40
) (
    input  logic [N-1:0]        req_i,
    input  logic [N-1:0][W-1:0] data_i,
    output logic [W-1:0]        data_o
);
    logic [N-1:0] grant;

    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant[i] = req_i[i];
        end else begin : g_rest
            assign grant[i] = req_i[i] & ~(|req_i[i-1:0]);
        end
    end

    always_comb begin
        data_o = '0;
        for (int i = 0; i < N; i++) begin
            data_o = data_o | ({W{grant[i]}} & data_i[i]);
        end
    end
endmodule

// File: rtl/cel_stat_next.sv
// Next status value: write-one-to-clear first, then the event on top.
module cel_stat_next import cel_pkg::*; #(
    parameter int unsigned NUM_ERR = 4
) (
    input  logic [REG_W-1:0]   stat_i,
    input  logic [REG_W-1:0]   clr_i,
    input  logic [NUM_ERR-1:0] types_i,
    output logic [REG_W-1:0]   stat_o,
    output logic               load_o
);
    logic [REG_W-1:0] wmask;
    logic [REG_W-1:0] kept;
    logic             evt;
    logic             fresh;

    always_comb begin
        wmask          = '0;
        wmask[MEC_BIT] = 1'b1;
        wmask[VLD_BIT] = 1'b1;
        for (int k = 0; k < NUM_ERR; k++) begin
            wmask[TYPE_TOP-k] = 1'b1;
        end
    end

    always_comb begin
        kept   = stat_i & ~(clr_i & wmask);
        evt    = |types_i;
        fresh  = evt & ~kept[VLD_BIT];
        stat_o = kept;
        load_o = fresh;
        if (fresh) begin
            stat_o[VLD_BIT] = 1'b1;
            for (int k = 0; k < NUM_ERR; k++) begin
                stat_o[TYPE_TOP-k] = types_i[k];
            end
        end else if (evt) begin
            stat_o[MEC_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/cel_read_mux.sv
module cel_read_mux import cel_pkg::*; #(
    parameter int unsigned NUM_ERR = 4,
    parameter int unsigned PA_W    = 40
) (
    input  logic [1:0]         sel_i,
    input  logic [REG_W-1:0]   stat_i,
    input  logic [PA_W-4:0]    addr_i,
    input  logic [NUM_ERR-1:0] en_i,
    output logic [REG_W-1:0]   rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (reg_sel_e'(sel_i))
            SEL_STATUS: rdata_o = stat_i;
            SEL_ADDR:   rdata_o[PA_W-1:3] = addr_i;
            SEL_ENABLE: rdata_o[NUM_ERR-1:0] = en_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cache_err_log.sv
module cache_err_log import cel_pkg::*; #(
    parameter int unsigned NUM_ERR = 4,
    parameter int unsigned PA_W    = 40
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          err_valid_i,
    input  logic [NUM_ERR-1:0]            err_type_i,
    input  logic [NUM_ERR-1:0][PA_W-1:0]  err_addr_i,
    input  logic                          reg_en_i,
    input  logic                          reg_we_i,
    input  logic [1:0]                    reg_addr_i,
    input  logic [REG_W-1:0]              reg_wdata_i,
    output logic [REG_W-1:0]              reg_rdata_o,
    output logic                          irq_o
);
    localparam int unsigned AKEEP = PA_W - 3;

    typedef struct packed {
        logic [REG_W-1:0]   stat;
        logic [AKEEP-1:0]   addr;
        logic [NUM_ERR-1:0] en;
    } log_state_t;

    log_state_t s_d, s_q;

    logic [NUM_ERR-1:0] evt_types;
    logic [PA_W-1:0]    pick_addr;
    logic [REG_W-1:0]   clr_mask;
    logic [REG_W-1:0]   stat_nx;
    logic               addr_load;
    logic               wr_stat;
    logic               wr_en;
    logic [NUM_ERR-1:0] types_q;
    logic [REG_W-1:0]   stat_q;
    logic [AKEEP-1:0]   addr_q;

    assign evt_types = err_valid_i ? err_type_i : '0;
    assign wr_stat   = reg_en_i & reg_we_i & (reg_sel_e'(reg_addr_i) == SEL_STATUS);
    assign wr_en     = reg_en_i & reg_we_i & (reg_sel_e'(reg_addr_i) == SEL_ENABLE);
    assign clr_mask  = wr_stat ? reg_wdata_i : '0;
    assign stat_q    = s_q.stat;
    assign addr_q    = s_q.addr;

    cel_prio_pick #(.N(NUM_ERR), .W(PA_W)) u_pick (
        .req_i  (evt_types),
        .data_i (err_addr_i),
        .data_o (pick_addr)
    );

    cel_stat_next #(.NUM_ERR(NUM_ERR)) u_next (
        .stat_i  (s_q.stat),
        .clr_i   (clr_mask),
        .types_i (evt_types),
        .stat_o  (stat_nx),
        .load_o  (addr_load)
    );

    cel_read_mux #(.NUM_ERR(NUM_ERR), .PA_W(PA_W)) u_rd (
        .sel_i   (reg_addr_i),
        .stat_i  (s_q.stat),
        .addr_i  (s_q.addr),
        .en_i    (s_q.en),
        .rdata_o (reg_rdata_o)
    );

    always_comb begin
        s_d      = s_q;
        s_d.stat = stat_nx;
        if (addr_load) begin
            s_d.addr = pick_addr[PA_W-1:3];
        end
        if (wr_en) begin
            s_d.en = reg_wdata_i[NUM_ERR-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_ERR; k++) begin
            types_q[k] = s_q.stat[TYPE_TOP-k];
        end
    end

    assign irq_o = s_q.stat[VLD_BIT] & |(types_q & s_q.en);
endmodule

// File: rtl/cel_checker.sv
module cel_checker import cel_pkg::*; #(
    parameter int unsigned NUM_ERR = 4,
    parameter int unsigned PA_W    = 40
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                err_valid_i,
    input logic [NUM_ERR-1:0]  err_type_i,
    input logic                reg_en_i,
    input logic                reg_we_i,
    input logic [1:0]          reg_addr_i,
    input logic                irq_o,
    input logic [REG_W-1:0]    stat_q,
    input logic [PA_W-4:0]     addr_q
);
    logic               evt;
    logic               wr_st;
    logic [NUM_ERR-1:0] types;

    assign evt   = err_valid_i & (|err_type_i);
    assign wr_st = reg_en_i & reg_we_i & (reg_addr_i == 2'd0);

    always_comb begin
        for (int k = 0; k < NUM_ERR; k++) begin
            types[k] = stat_q[TYPE_TOP-k];
        end
    end

    AST_FIRST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt && !stat_q[VLD_BIT] |=> stat_q[VLD_BIT]); // R2
    AST_SECOND_SETS_MEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt && stat_q[VLD_BIT] && !wr_st |=> stat_q[MEC_BIT]); // R3
    AST_ADDR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_q[VLD_BIT] && !wr_st |=> $stable(addr_q)); // R3
    AST_TYPES_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_q[VLD_BIT] && !wr_st |=> $stable(types)); // R3
    AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt && !wr_st |=> $stable(stat_q)); // R10
    AST_ADDR_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt |=> $stable(addr_q)); // R10
    AST_IRQ_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_q[VLD_BIT] |-> !irq_o); // R8
    AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt && wr_st |=> stat_q[VLD_BIT]); // R9
endmodule

bind cache_err_log cel_checker #(.NUM_ERR(NUM_ERR), .PA_W(PA_W)) u_cel_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_valid_i (err_valid_i),
    .err_type_i  (err_type_i),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .irq_o       (irq_o),
    .stat_q      (stat_q),
    .addr_q      (addr_q)
);

// File: tb/test_cache_err_log.sv
module test_cache_err_log;
    localparam int unsigned NE = 4;
    localparam int unsigned PW = 40;
    localparam logic [63:0] B_MEC = 64'h8000_0000_0000_0000;
    localparam logic [63:0] B_VLD = 64'h4000_0000_0000_0000;
    localparam logic [63:0] B_T0  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] B_T1  = 64'h1000_0000_0000_0000;
    localparam logic [63:0] B_T2  = 64'h0800_0000_0000_0000;
    localparam logic [63:0] B_T3  = 64'h0400_0000_0000_0000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    err_valid = 1'b0;
    logic [NE-1:0]           err_type = '0;
    logic [NE-1:0][PW-1:0]   err_addr = '0;
    logic                    reg_en = 1'b0;
    logic                    reg_we = 1'b0;
    logic [1:0]              reg_addr = 2'd0;
    logic [63:0]             reg_wdata = '0;
    logic [63:0]             reg_rdata;
    logic                    irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cache_err_log #(.NUM_ERR(NE), .PA_W(PW)) i_cache_err_log (
        .clk_i(clk), .rst_ni(rst_n), .err_valid_i(err_valid), .err_type_i(err_type),
        .err_addr_i(err_addr), .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [63:0] v);
        reg_addr = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = sel; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic raise(input logic [NE-1:0] t, input logic v, input logic [NE-1:0][PW-1:0] a);
        err_valid = v; err_type = t; err_addr = a;
        @(negedge clk);
        err_valid = 1'b0; err_type = '0; err_addr = '0;
    endtask

    task automatic raise_and_wr(input logic [NE-1:0] t, input logic [NE-1:0][PW-1:0] a,
                                input logic [63:0] d);
        err_valid = 1'b1; err_type = t; err_addr = a;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = d;
        @(negedge clk);
        err_valid = 1'b0; err_type = '0; err_addr = '0;
        reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [NE-1:0][PW-1:0] one_addr(input int idx, input logic [PW-1:0] a);
        logic [NE-1:0][PW-1:0] r;
        r = '0;
        r[idx] = a;
        return r;
    endfunction

    task automatic t_reset;
        logic [63:0] v;
        rd(2'd0, v); check(v, 64'h0, "R1 status");
        rd(2'd1, v); check(v, 64'h0, "R1 address");
        rd(2'd2, v); check(v, 64'h0, "R1 enable");
        check(64'(irq), 64'h0, "R1 irq");
    endtask

    task automatic t_first;
        logic [63:0] v;
        raise(4'b0100, 1'b1, one_addr(2, 40'h20_2000_aa0d));
        rd(2'd0, v); check(v, B_VLD | B_T2, "R2 status");
        rd(2'd1, v); check(v, 64'h20_2000_aa08, "R7 address low bits");
        check(64'(irq), 64'h0, "R8 irq masked");
    endtask

    task automatic t_second;
        logic [63:0] v;
        raise(4'b0001, 1'b1, one_addr(0, 40'h30_3000_aa00));
        rd(2'd0, v); check(v, B_MEC | B_VLD | B_T2, "R3 status");
        rd(2'd1, v); check(v, 64'h20_2000_aa08, "R3 address kept");
    endtask

    task automatic t_w1c;
        logic [63:0] v;
        wr(2'd0, 64'h0);
        rd(2'd0, v); check(v, B_MEC | B_VLD | B_T2, "R4 zero mask");
        wr(2'd0, B_MEC);
        rd(2'd0, v); check(v, B_VLD | B_T2, "R4 partial mask");
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); check(v, 64'h0, "R4 full mask");
    endtask

    task automatic t_fresh;
        logic [63:0] v;
        raise(4'b1000, 1'b1, one_addr(3, 40'h12_3456_7890));
        rd(2'd0, v); check(v, B_VLD | B_T3, "R5 status");
        rd(2'd1, v); check(v, 64'h12_3456_7890, "R5 address");
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_simul;
        logic [63:0] v;
        logic [NE-1:0][PW-1:0] a;
        a = '0;
        a[1] = 40'hAA_0000_1000;
        a[2] = 40'hBB_0000_2000;
        raise(4'b0110, 1'b1, a);
        rd(2'd0, v); check(v, B_VLD | B_T1 | B_T2, "R6 status");
        rd(2'd1, v); check(v, 64'hAA_0000_1000, "R6 address priority");
    endtask

    task automatic t_irq;
        logic [63:0] v;
        wr(2'd2, 64'hFFFF_FFFF_FFFF_FFF4);
        rd(2'd2, v); check(v, 64'h4, "R8 enable read");
        check(64'(irq), 64'h1, "R8 irq on");
        wr(2'd2, 64'h9);
        check(64'(irq), 64'h0, "R8 irq type disabled");
        wr(2'd2, 64'h2);
        check(64'(irq), 64'h1, "R8 irq other type");
        wr(2'd0, B_VLD);
        check(64'(irq), 64'h0, "R8 irq after clear");
        rd(2'd0, v); check(v, B_T1 | B_T2, "R4 only valid cleared");
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd2, 64'h0);
    endtask

    task automatic t_same_cycle;
        logic [63:0] v;
        raise(4'b1000, 1'b1, one_addr(3, 40'h01_0000_0040));
        raise_and_wr(4'b0001, one_addr(0, 40'h02_0000_0080), 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); check(v, B_VLD | B_T0, "R9 full clear plus event");
        rd(2'd1, v); check(v, 64'h02_0000_0080, "R9 address fresh");
        raise_and_wr(4'b0010, one_addr(1, 40'h03_0000_00c0), B_MEC);
        rd(2'd0, v); check(v, B_MEC | B_VLD | B_T0, "R9 mec clear loses");
        rd(2'd1, v); check(v, 64'h02_0000_0080, "R9 address kept");
    endtask

    task automatic t_ignore;
        logic [63:0] v;
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd1, v); check(v, 64'h02_0000_0080, "R10 address write ignored");
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        raise(4'b0000, 1'b1, one_addr(0, 40'h0F_0000_0000));
        rd(2'd0, v); check(v, 64'h0, "R10 empty type vector");
        raise(4'b0101, 1'b0, one_addr(0, 40'h0E_0000_0000));
        rd(2'd0, v); check(v, 64'h0, "R10 no strobe");
        rd(2'd1, v); check(v, 64'h02_0000_0080, "R10 address unchanged");
        rd(2'd3, v); check(v, 64'h0, "R7 unused select");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first();
        t_second();
        t_w1c();
        t_fresh();
        t_simul();
        t_irq();
        t_same_cycle();
        t_ignore();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule